// File: doc/BRIEF.md
# Dual-Half Page Hamming ECC Generator

This block sits beside the 16-bit data port of a NAND flash host. Software steers it with 8-bit mode codes. One code clears the parity state. One code makes every following 16-bit data transfer fold its two bytes into the running code. One code turns the data port into a readout of the finished code. A 512-byte span is treated as two independent 256-byte halves. Each half gets a three-byte single-error-correcting Hamming code, made of two bytes of line parity over the byte index and one byte of column parity over the bit position. One bit error per half can then be located, so the span as a whole has a strength of two.

The six code bytes are read back as three 16-bit words, and their byte order is interleaved. A byte counter moves accumulation to the second half once 256 bytes have been taken. It stops accumulating once 512 bytes have been taken. Correction and syndrome decoding are left to the host. After a clear, the host issues one dummy data read before it selects accumulation. That read must leave the code untouched.

Top module: `ecc_dualhalf_gen`

## Requirements
- R1: After reset, or one cycle after mode code 0xF4 is written, the parity state is empty, the readout index is 0, and every result word reads 16'hFFFF.
- R2: Mode code 0xF4 clears, 0xB4 accumulates and 0xD4 selects result readout. Any other code selects an idle mode in which data transfers neither accumulate nor advance the readout index.
- R3: A data transfer made outside accumulate mode leaves the code unchanged. This covers the dummy read that follows a clear.
- R4: Each accumulated transfer carries two bytes. Bits 7:0 hold the byte with the lower index and bits 15:8 hold the next byte.
- R5: Line parity bit 2k+1 is the XOR of every data bit of the bytes whose in-half index has bit k set, and bit 2k is the same XOR over the bytes where that index bit is clear (k = 0..7).
- R6: Column parity bit 2j+1 is the XOR over all bytes of the data bits whose bit position has bit j set, and bit 2j covers the positions where it is clear (j = 0..2). The column byte carries CP5..CP0 in bits 7:2, and its bits 1:0 are always 11.
- R7: All parity bits are output inverted, so a half that is all 0xFF, or all zero, gives three 0xFF code bytes.
- R8: Bytes 0..255 after a clear go to the first half and bytes 256..511 go to the second half.
- R9: Bytes after the 512th are ignored until the next clear.
- R10: Result word 0 is {half0 LP15..8, half0 LP7..0}. Word 1 is {half1 LP7..0, half0 column byte}. Word 2 is {half1 column byte, half1 LP15..8}. In each pair the high byte is written first.
- R11: In result mode, each data transfer advances the readout index by one, and the index wraps from word 2 to word 0. Writing 0xD4 sets the index to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Strobe that loads mode_code |
| mode_code | input | 8 | Mode code (0xF4 clear, 0xB4 accumulate, 0xD4 result, others idle) |
| dat_strobe | input | 1 | One 16-bit data-port transfer (read or write) this cycle |
| dat_bus | input | 16 | The two bytes on the data port, lower index in bits 7:0 |
| res_word | output | 16 | Result word selected by the readout index |

## Verification
A corrupted line-parity accumulator shows up in the next result read as a word that differs from the index-weighted XOR of the bytes sent. A wrong byte count shows up as bytes landing in the wrong half, or as late bytes still altering the code. Both appear one cycle after the transfer that caused them. A broken readout index shows up within three reads, because the words come back out of order or fail to wrap. Every output word is compared each cycle with a model that recomputes both codes from the stored bytes, so a fault is reported in the cycle it first reaches res_word.

// File: rtl/ecc_dualhalf_pkg.sv
package ecc_dualhalf_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE,
      MODE_CLEAR,
      MODE_ACCUM,
      MODE_RESULT
   } ecc_mode_e;

   localparam int unsigned HALVES    = 2;
   localparam int unsigned RES_WORDS = 3;
   localparam int unsigned RES_IDX_W = 2;
   localparam int unsigned LP_OUT_W  = 16;

   // Inverted column code byte: CP5..CP0 in bits 7:2, bits 1:0 fixed high.
   function automatic logic [7:0] column_code(input logic [7:0] col);
      logic [2:0] odd_p;
      logic [2:0] even_p;
      logic [7:0] cb;
      odd_p  = '0;
      even_p = '0;
      for (int j = 0; j < 3; j++) begin
         for (int p = 0; p < 8; p++) begin
            if (((p >> j) & 1) == 1) odd_p[j]  = odd_p[j]  ^ col[p];
            else                     even_p[j] = even_p[j] ^ col[p];
         end
      end
      cb = 8'h03;
      for (int j = 0; j < 3; j++) begin
         cb[2 + 2*j + 1] = ~odd_p[j];
         cb[2 + 2*j]     = ~even_p[j];
      end
      return cb;
   endfunction

endpackage

// File: rtl/ecc_dualhalf_ctrl.sv
module ecc_dualhalf_ctrl
   import ecc_dualhalf_pkg::*;
#(
   parameter int unsigned HALF_BYTES  = 256,
   parameter logic [7:0]  CODE_CLEAR  = 8'hF4,
   parameter logic [7:0]  CODE_ACCUM  = 8'hB4,
   parameter logic [7:0]  CODE_RESULT = 8'hD4,
   localparam int unsigned IDX_W = $clog2(HALF_BYTES),
   localparam int unsigned SPAN  = 2 * HALF_BYTES,
   localparam int unsigned CNT_W = $clog2(SPAN) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [7:0]           mode_code,
   input  logic                 dat_strobe,
   output logic                 clear_now,
   output logic                 acc_take,
   output logic                 half_sel,
   output logic [IDX_W-1:0]     base_idx,
   output logic [CNT_W-1:0]     byte_cnt,
   output logic [RES_IDX_W-1:0] rd_idx,
   output logic                 in_acc,
   output logic                 in_res
);

   ecc_mode_e mode_q;
   ecc_mode_e mode_d;
   logic      span_open;
   logic      idx_zero;

   always_comb begin
      if      (mode_code == CODE_CLEAR)  mode_d = MODE_CLEAR;
      else if (mode_code == CODE_ACCUM)  mode_d = MODE_ACCUM;
      else if (mode_code == CODE_RESULT) mode_d = MODE_RESULT;
      else                               mode_d = MODE_IDLE;
   end

   assign clear_now = mode_wr && (mode_d == MODE_CLEAR);
   assign idx_zero  = mode_wr && ((mode_d == MODE_CLEAR) || (mode_d == MODE_RESULT));
   assign in_acc    = (mode_q == MODE_ACCUM);
   assign in_res    = (mode_q == MODE_RESULT);
   assign span_open = (byte_cnt < CNT_W'(SPAN));
   assign acc_take  = dat_strobe && in_acc && span_open;
   assign half_sel  = byte_cnt[IDX_W];
   assign base_idx  = byte_cnt[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= MODE_IDLE;
      else if (mode_wr) mode_q <= mode_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         byte_cnt <= '0;
      else if (clear_now) byte_cnt <= '0;
      else if (acc_take)  byte_cnt <= byte_cnt + CNT_W'(2);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 rd_idx <= '0;
      else if (idx_zero)          rd_idx <= '0;
      else if (dat_strobe && in_res) begin
         if (rd_idx == RES_IDX_W'(RES_WORDS - 1)) rd_idx <= '0;
         else                                     rd_idx <= rd_idx + 1'b1;
      end
   end

endmodule

// File: rtl/ecc_dualhalf_acc.sv
module ecc_dualhalf_acc #(
   parameter int unsigned IDX_W = 8,
   localparam int unsigned LPW  = 2 * IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [IDX_W-1:0] base_idx,
   input  logic [7:0]       byte_lo,
   input  logic [7:0]       byte_hi,
   output logic [LPW-1:0]   lp_q,
   output logic [7:0]       col_q
);

   logic             par_lo;
   logic             par_hi;
   logic [IDX_W-1:0] idx_hi;
   logic [LPW-1:0]   lp_delta;

   assign par_lo = ^byte_lo;
   assign par_hi = ^byte_hi;
   assign idx_hi = base_idx | IDX_W'(1);

   for (genvar k = 0; k < IDX_W; k++) begin : g_line
      assign lp_delta[2*k+1] = (base_idx[k] & par_lo) ^ (idx_hi[k] & par_hi);
      assign lp_delta[2*k]   = (~base_idx[k] & par_lo) ^ (~idx_hi[k] & par_hi);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lp_q  <= '0;
         col_q <= '0;
      end else if (en) begin
         lp_q  <= lp_q ^ lp_delta;
         col_q <= col_q ^ byte_lo ^ byte_hi;
      end
   end

endmodule

// File: rtl/ecc_dualhalf_pack.sv
module ecc_dualhalf_pack
   import ecc_dualhalf_pkg::*;
#(
   parameter int unsigned LPW = 16
) (
   input  logic [HALVES*LPW-1:0] lp_all,
   input  logic [HALVES*8-1:0]   col_all,
   input  logic [RES_IDX_W-1:0]  rd_idx,
   output logic [15:0]           res_word
);

   logic [7:0] lp_lo [HALVES];
   logic [7:0] lp_hi [HALVES];
   logic [7:0] cbyte [HALVES];

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [LP_OUT_W-1:0] lp_wide;
      if (LPW < LP_OUT_W) begin : g_pad
         assign lp_wide = {{(LP_OUT_W-LPW){1'b0}}, lp_all[h*LPW +: LPW]};
      end else begin : g_full
         assign lp_wide = lp_all[h*LPW +: LP_OUT_W];
      end
      assign lp_lo[h] = ~lp_wide[7:0];
      assign lp_hi[h] = ~lp_wide[15:8];
      assign cbyte[h] = column_code(col_all[h*8 +: 8]);
   end

   always_comb begin
      case (rd_idx)
         2'd0:    res_word = {lp_hi[0], lp_lo[0]};
         2'd1:    res_word = {lp_lo[1], cbyte[0]};
         2'd2:    res_word = {cbyte[1], lp_hi[1]};
         default: res_word = 16'hFFFF;
      endcase
   end

endmodule

// File: rtl/ecc_dualhalf_gen.sv
module ecc_dualhalf_gen
   import ecc_dualhalf_pkg::*;
#(
   parameter int unsigned HALF_BYTES  = 256,
   parameter logic [7:0]  CODE_CLEAR  = 8'hF4,
   parameter logic [7:0]  CODE_ACCUM  = 8'hB4,
   parameter logic [7:0]  CODE_RESULT = 8'hD4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode_wr,
   input  logic [7:0]  mode_code,
   input  logic        dat_strobe,
   input  logic [15:0] dat_bus,
   output logic [15:0] res_word
);

   localparam int unsigned IDX_W = $clog2(HALF_BYTES);
   localparam int unsigned LPW   = 2 * IDX_W;
   localparam int unsigned SPAN  = 2 * HALF_BYTES;
   localparam int unsigned CNT_W = $clog2(SPAN) + 1;

   if ((HALF_BYTES < 2) || (HALF_BYTES > 256) ||
       ((HALF_BYTES & (HALF_BYTES - 1)) != 0)) begin : g_bad_half
      $error("HALF_BYTES must be a power of two from 2 to 256");
   end
   if ((CODE_CLEAR == CODE_ACCUM) || (CODE_CLEAR == CODE_RESULT) ||
       (CODE_ACCUM == CODE_RESULT)) begin : g_bad_codes
      $error("mode codes must be distinct");
   end

   logic                 clear_now;
   logic                 acc_take;
   logic                 half_sel;
   logic [IDX_W-1:0]     base_idx;
   logic [CNT_W-1:0]     byte_cnt;
   logic [RES_IDX_W-1:0] rd_idx;
   logic                 in_acc;
   logic                 in_res;
   logic [HALVES*LPW-1:0] lp_all;
   logic [HALVES*8-1:0]   col_all;

   ecc_dualhalf_ctrl #(
      .HALF_BYTES (HALF_BYTES),
      .CODE_CLEAR (CODE_CLEAR),
      .CODE_ACCUM (CODE_ACCUM),
      .CODE_RESULT(CODE_RESULT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_code (mode_code),
      .dat_strobe(dat_strobe),
      .clear_now (clear_now),
      .acc_take  (acc_take),
      .half_sel  (half_sel),
      .base_idx  (base_idx),
      .byte_cnt  (byte_cnt),
      .rd_idx    (rd_idx),
      .in_acc    (in_acc),
      .in_res    (in_res)
   );

   for (genvar h = 0; h < HALVES; h++) begin : g_acc
      ecc_dualhalf_acc #(.IDX_W(IDX_W)) u_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clear_now),
         .en      (acc_take && (half_sel == 1'(h))),
         .base_idx(base_idx),
         .byte_lo (dat_bus[7:0]),
         .byte_hi (dat_bus[15:8]),
         .lp_q    (lp_all[h*LPW +: LPW]),
         .col_q   (col_all[h*8 +: 8])
      );
   end

   ecc_dualhalf_pack #(.LPW(LPW)) u_pack (
      .lp_all  (lp_all),
      .col_all (col_all),
      .rd_idx  (rd_idx),
      .res_word(res_word)
   );

endmodule

// File: rtl/ecc_dualhalf_gen_chk.sv
module ecc_dualhalf_gen_chk #(
   parameter int unsigned HALF_BYTES = 256,
   parameter logic [7:0]  CODE_CLEAR = 8'hF4,
   localparam int unsigned IDX_W = $clog2(HALF_BYTES),
   localparam int unsigned LPW   = 2 * IDX_W,
   localparam int unsigned SPAN  = 2 * HALF_BYTES,
   localparam int unsigned CNT_W = $clog2(SPAN) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_wr,
   input logic [7:0]       mode_code,
   input logic             dat_strobe,
   input logic             in_acc,
   input logic             in_res,
   input logic [CNT_W-1:0] byte_cnt,
   input logic [1:0]       rd_idx,
   input logic [2*LPW-1:0] lp_all,
   input logic [15:0]      col_all,
   input logic [15:0]      res_word
);

   logic clr_wr;
   assign clr_wr = mode_wr && (mode_code == CODE_CLEAR);

   // R1
   clear_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (res_word == 16'hFFFF));

   // R3
   hold_outside_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_acc && !clr_wr) |=> ($stable(lp_all) && $stable(col_all)));

   // R8
   upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((byte_cnt < CNT_W'(HALF_BYTES)) && !clr_wr) |=>
         ($stable(lp_all[2*LPW-1:LPW]) && $stable(col_all[15:8])));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= CNT_W'(SPAN));

   // R9
   span_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((byte_cnt == CNT_W'(SPAN)) && !clr_wr) |=>
         ($stable(lp_all) && $stable(col_all)));

   // R11
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_res && dat_strobe && !mode_wr && (rd_idx == 2'd2)) |=> (rd_idx == 2'd0));

   // R11
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx != 2'd3);

endmodule

bind ecc_dualhalf_gen ecc_dualhalf_gen_chk #(
   .HALF_BYTES(HALF_BYTES),
   .CODE_CLEAR(CODE_CLEAR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_wr   (mode_wr),
   .mode_code (mode_code),
   .dat_strobe(dat_strobe),
   .in_acc    (in_acc),
   .in_res    (in_res),
   .byte_cnt  (byte_cnt),
   .rd_idx    (rd_idx),
   .lp_all    (lp_all),
   .col_all   (col_all),
   .res_word  (res_word)
);

// File: tb/ecc_dualhalf_gen_bench.sv
`timescale 1ns/1ps
module ecc_dualhalf_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [7:0]  mode_code = 8'h00;
   logic        dat_strobe = 1'b0;
   logic [15:0] dat_bus = 16'h0000;
   logic [15:0] res_word;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference state
   byte unsigned mem [2][256];
   int m_mode = 0;
   int m_cnt  = 0;
   int m_idx  = 0;
   bit m_live = 0;

   always #2 clk = ~clk;

   ecc_dualhalf_gen u_ecc_dualhalf_gen (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
      .dat_strobe(dat_strobe), .dat_bus(dat_bus), .res_word(res_word)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: res_word=%h expected %h", req, act, exp);
      end
   endtask

   function automatic void wipe();
      for (int h = 0; h < 2; h++)
         for (int i = 0; i < 256; i++) mem[h][i] = 8'h00;
   endfunction

   function automatic logic [23:0] half_code(input int h);
      logic [15:0] lp;
      logic [5:0]  cp;
      logic [7:0]  cb;
      lp = '0;
      cp = '0;
      for (int i = 0; i < 256; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (mem[h][i][b]) begin
               for (int k = 0; k < 8; k++) begin
                  if (((i >> k) & 1) == 1) lp[2*k+1] = ~lp[2*k+1];
                  else                     lp[2*k]   = ~lp[2*k];
               end
               for (int j = 0; j < 3; j++) begin
                  if (((b >> j) & 1) == 1) cp[2*j+1] = ~cp[2*j+1];
                  else                     cp[2*j]   = ~cp[2*j];
               end
            end
         end
      end
      cb = {~cp, 2'b11};
      return {cb, ~lp[15:8], ~lp[7:0]};
   endfunction

   function automatic logic [15:0] exp_word(input int idx);
      logic [23:0] c0;
      logic [23:0] c1;
      c0 = half_code(0);
      c1 = half_code(1);
      case (idx)
         0:       return {c0[15:8], c0[7:0]};
         1:       return {c1[7:0], c0[23:16]};
         default: return {c1[23:16], c1[15:8]};
      endcase
   endfunction

   // behavioural reference, updated on the same edge as the design
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         wipe();
         m_mode = 0; m_cnt = 0; m_idx = 0; m_live = 1;
      end else begin
         if (dat_strobe) begin
            if (m_mode == 8'hB4 && m_cnt < 512) begin
               mem[m_cnt / 256][m_cnt % 256]         = dat_bus[7:0];
               mem[(m_cnt + 1) / 256][(m_cnt + 1) % 256] = dat_bus[15:8];
               m_cnt += 2;
            end else if (m_mode == 8'hD4) begin
               m_idx = (m_idx + 1) % 3;
            end
         end
         if (mode_wr) begin
            m_mode = int'(mode_code);
            if (mode_code == 8'hF4) begin
               wipe(); m_cnt = 0; m_idx = 0;
            end else if (mode_code == 8'hD4) begin
               m_idx = 0;
            end
         end
      end
      if (cycles >= 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && m_live) check(cur_req, res_word, exp_word(m_idx));
   end

   task automatic set_mode(input logic [7:0] code);
      @(negedge clk); mode_wr = 1'b1; mode_code = code;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic xfer(input logic [15:0] w);
      @(negedge clk); dat_strobe = 1'b1; dat_bus = w;
      @(negedge clk); dat_strobe = 1'b0;
   endtask

   task automatic read3(input string req, input logic [15:0] w0,
                        input logic [15:0] w1, input logic [15:0] w2);
      set_mode(8'hD4);
      check(req, res_word, w0); xfer(16'h0000);
      check(req, res_word, w1); xfer(16'h0000);
      check(req, res_word, w2); xfer(16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cur_req = "R1";
      check("R1", res_word, 16'hFFFF);
      read3("R1", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // R3 dummy read after clear, then single byte 0x01 at index 0 (R5 R6 R10)
      cur_req = "R3";
      set_mode(8'hF4);
      check("R1", res_word, 16'hFFFF);
      xfer(16'h1234);
      cur_req = "R5";
      set_mode(8'hB4);
      xfer(16'h0001);
      read3("R10", 16'hAAAA, 16'hFFAB, 16'hFFFF);
      // R11 wrap back to word 0
      cur_req = "R11";
      check("R11", res_word, 16'hAAAA);
      xfer(16'h0000);
      check("R11", res_word, 16'hFFAB);
      set_mode(8'hD4);
      check("R11", res_word, 16'hAAAA);

      // R2 unknown code is idle: no accumulation, no index move
      cur_req = "R2";
      set_mode(8'h94);
      xfer(16'hFFFF); xfer(16'h0F0F);
      set_mode(8'hD4);
      check("R2", res_word, 16'hAAAA);

      // R4 byte order within a transfer
      cur_req = "R4";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      xfer(16'h0100);
      read3("R4", 16'hAAA9, 16'hFFAB, 16'hFFFF);

      // R5 R6 byte 0x80 at index 255
      cur_req = "R6";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      for (int i = 0; i < 127; i++) xfer(16'h0000);
      xfer(16'h8000);
      read3("R6", 16'h5555, 16'hFF57, 16'hFFFF);

      // R8 first byte of the second half
      cur_req = "R8";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      for (int i = 0; i < 128; i++) xfer(16'h0000);
      xfer(16'h0001);
      read3("R8", 16'hFFFF, 16'hAAFF, 16'hABAA);

      // R7 erased span
      cur_req = "R7";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      for (int i = 0; i < 256; i++) xfer(16'hFFFF);
      read3("R7", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // R9 full zero span, then late bytes ignored
      cur_req = "R9";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      for (int i = 0; i < 256; i++) xfer(16'h0000);
      xfer(16'h0001); xfer(16'h8000);
      read3("R9", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // pseudo-random span checked against the model every cycle
      cur_req = "R5";
      set_mode(8'hF4); xfer(16'h0000); set_mode(8'hB4);
      for (int i = 0; i < 256; i++) xfer(16'($urandom));
      cur_req = "R10";
      set_mode(8'hD4);
      for (int i = 0; i < 4; i++) xfer(16'h0000);

      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule